// File: doc/BRIEF.md
# Speculative Thread Order Manager

This block keeps track of a small pool of thread units that run speculative threads. Each unit holds at most one thread. The block keeps an ordered list of the units that are active, in program order. The entry at the front of the list is the one thread that is not speculative. All entries behind it are speculative.

A spawn request carries three things: the start-point tag of the new thread, a predicted position in the order list, and the unit of the parent thread. Any active thread may be the parent. Because the new thread goes in at the predicted slot, threads can be created out of program order. The block places the new thread in the lowest-numbered free unit. If no unit is free, it cancels the youngest listed thread that sits behind the insertion slot and reuses that unit. If no such thread exists, it drops the request.

When a thread reaches the start point of another thread, the environment reports a finish event. The block acts on a finish only for the thread at the front of the list. It first checks the order: the reached tag must equal the tag of the second thread in the list. If the order holds, it asks the environment to check the input values. Depending on the answers, the block either commits the front thread or squashes the whole list behind it. A committed unit is held, and not freed, while any child it spawned is still running its pre-computation slice.

Top module: `spec_order_mgr`

## Requirements
- R1: After reset, no thread is active. `head_valid`, `live_cnt`, `val_req`, `squash`, `free`, `spawn_gnt` and `spawn_drop` are all 0, and `spawn_rdy` is 1.
- R2: An accepted spawn with a free unit takes the lowest-numbered free unit. In the next cycle `spawn_gnt` is 1 and `spawn_unit` names that unit, `live_cnt` has grown by one, and no squash occurs.
- R3: The insertion slot (0 = front of the list) is found as follows. If the list is empty, the slot is 0. A requested slot of 0 becomes 1. A requested slot larger than `live_cnt` becomes `live_cnt`. Any other slot is used as given. The entries at that slot and behind it move back by one.
- R4: If no unit is free and the slot is smaller than `live_cnt`, the last entry in the list is cancelled. In one cycle, `squash` pulses on that unit alone, `spawn_gnt` is 1, and `spawn_unit` names the same unit. The new thread then sits at the slot.
- R5: If no unit is free and the slot equals `live_cnt`, the request is dropped. `spawn_drop` pulses, there is no grant and no squash, and the list does not change.
- R6: `head_unit` is the front entry of the list, which is the non-speculative thread. `head_valid` is 1 whenever `live_cnt` is not 0.
- R7: A finish from a thread that is not at the front is recorded. It triggers nothing until that thread reaches the front. A finish for a unit that is not in the list is ignored. While the front thread has an unresolved finish, `spawn_rdy` is 0 and no spawn is accepted.
- R8: If the front thread's reached tag differs from the second entry's start tag, then one cycle later every listed unit except the front one is squashed and `live_cnt` is 1. The front thread carries on, and `spawn_rdy` returns to 1.
- R9: If the tags match, `val_req` is 1 and `val_unit` names the second entry. The block keeps this state until `val_rsp_v` is high on a clock edge.
- R10: A validation answer with `val_rsp_ok` = 0 squashes every listed unit except the front one and leaves `live_cnt` at 1, with no `free` pulse.
- R11: A validation answer with `val_rsp_ok` = 1 commits the front thread. In the next cycle `free` pulses on its unit, the second entry becomes `head_unit`, and `live_cnt` drops by one.
- R12: If a child of the committing unit is still in its slice, that unit is held. It gets no `free` pulse and is not granted to a new spawn. Its `free` pulse comes two cycles after the clock edge that samples the last such child's `slice_done`.
- R13: A finish from the front thread when it is the only listed thread leads to no squash and no request. Two cycles later `spawn_rdy` is 1 again and the thread carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Spawn request, held until accepted while `spawn_rdy` is high |
| spawn_tag | input | TW | Start-point tag of the new thread |
| spawn_pos | input | PW | Predicted slot in the order list |
| spawn_parent | input | UW | Unit of the spawning thread |
| spawn_rdy | output | 1 | Spawn requests are accepted |
| spawn_gnt | output | 1 | Pulse: the last accepted spawn was granted |
| spawn_drop | output | 1 | Pulse: the last accepted spawn was dropped |
| spawn_unit | output | UW | Unit granted to the new thread |
| slice_done | input | NU | Per unit: its thread finished its pre-computation slice |
| fin_valid | input | 1 | A thread reached a start point |
| fin_unit | input | UW | Unit of the finishing thread |
| fin_tag | input | TW | Start-point tag that was reached |
| val_req | output | 1 | Input-value check requested |
| val_unit | output | UW | Unit whose inputs are to be checked |
| val_rsp_v | input | 1 | Validation answer is present |
| val_rsp_ok | input | 1 | Validation answer: inputs were correct |
| squash | output | NU | Per unit one-cycle squash pulse |
| free | output | NU | Per unit one-cycle release pulse after commit |
| head_valid | output | 1 | At least one thread is active |
| head_unit | output | UW | Unit of the non-speculative thread |
| live_cnt | output | PW | Number of listed threads |

## Verification
A sweep covers every combination of requested slots, from 0 to 4, over the second, third and fourth spawns. This separates the slot clamping and out-of-order insertion from simple appending. A fifth spawn into the full pool then tries each slot, which tells eviction of the youngest entry apart from a drop. Each list is drained by committing thread after thread, and each validation request must name the expected next unit, so the entire order is read back. Directed sequences then compare a tag mismatch with a failed value check and with a passed one. They also exercise an early finish from a speculative thread, a lone finishing thread, and a commit that is held by a child still in its slice.

// File: rtl/som_pkg.sv
package som_pkg;
   typedef enum logic [1:0] {
      HD_IDLE,
      HD_RESUME,
      HD_SQUASH,
      HD_COMMIT
   } head_act_e;
endpackage

// File: rtl/som_pick.sv
module som_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (IW < $clog2(N)) begin : g_bad_iw
      $error("som_pick: IW too narrow for N");
   end

   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/som_list.sv
module som_list #(
   parameter int NU = 4,
   parameter int UW = 2,
   parameter int PW = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   trunc_en,
   input  logic [PW-1:0]          trunc_len,
   input  logic                   pop_en,
   input  logic                   ins_en,
   input  logic [PW-1:0]          ins_pos,
   input  logic [UW-1:0]          ins_unit,
   output logic [NU-1:0][UW-1:0]  ord,
   output logic [PW-1:0]          cnt,
   output logic [NU-1:0]          member,
   output logic [UW-1:0]          last_unit
);
   if (PW < $clog2(NU + 1)) begin : g_bad_pw
      $error("som_list: PW cannot hold NU");
   end

   logic [NU-1:0][UW-1:0] s_ord, n_ord;
   logic [PW-1:0]         n_cnt;

   always_comb begin
      s_ord = ord;
      n_cnt = cnt;
      if (trunc_en) n_cnt = trunc_len;
      if (pop_en) begin
         for (int i = 0; i < NU - 1; i++) s_ord[i] = ord[i+1];
         n_cnt = n_cnt - 1'b1;
      end
      n_ord = s_ord;
      if (ins_en) begin
         if (ins_pos == '0) n_ord[0] = ins_unit;
         for (int i = 1; i < NU; i++) begin
            if (PW'(i) == ins_pos)     n_ord[i] = ins_unit;
            else if (PW'(i) > ins_pos) n_ord[i] = s_ord[i-1];
         end
         n_cnt = n_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord <= '0;
         cnt <= '0;
      end else begin
         ord <= n_ord;
         cnt <= n_cnt;
      end
   end

   always_comb begin
      member    = '0;
      last_unit = ord[0];
      for (int i = 0; i < NU; i++) begin
         if (PW'(i) < cnt) member[ord[i]] = 1'b1;
         if (PW'(i + 1) == cnt) last_unit = ord[i];
      end
   end

   // R3
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(NU));
   // R3
   ins_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> ((trunc_en ? trunc_len : cnt) < PW'(NU)));
endmodule

// File: rtl/som_slice.sv
module som_slice #(
   parameter int NU = 4,
   parameter int UW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_en,
   input  logic [UW-1:0] start_unit,
   input  logic [UW-1:0] start_parent,
   input  logic [NU-1:0] kill,
   input  logic [NU-1:0] done,
   input  logic          commit_en,
   input  logic [UW-1:0] commit_unit,
   output logic [NU-1:0] held,
   output logic [NU-1:0] free_p
);
   logic [NU-1:0]         in_sl;
   logic [NU-1:0][UW-1:0] par;
   logic [NU-1:0]         has_child;

   always_comb begin
      has_child = '0;
      for (int j = 0; j < NU; j++) begin
         if (in_sl[j]) has_child[par[j]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_sl  <= '0;
         par    <= '0;
         held   <= '0;
         free_p <= '0;
      end else begin
         for (int u = 0; u < NU; u++) begin
            if (start_en && start_unit == UW'(u)) begin
               in_sl[u] <= 1'b1;
               par[u]   <= start_parent;
            end else if (kill[u] || done[u]) begin
               in_sl[u] <= 1'b0;
            end
            free_p[u] <= 1'b0;
            if (commit_en && commit_unit == UW'(u)) begin
               if (has_child[u]) held[u]   <= 1'b1;
               else              free_p[u] <= 1'b1;
            end else if (held[u] && !has_child[u]) begin
               held[u]   <= 1'b0;
               free_p[u] <= 1'b1;
            end
         end
      end
   end

   // R12
   held_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_en |-> !held[start_unit]);
   // R12
   held_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held & free_p) == '0);
endmodule

// File: rtl/spec_order_mgr.sv
module spec_order_mgr
   import som_pkg::*;
#(
   parameter int NU = 4,
   parameter int TW = 8,
   localparam int UW = (NU > 1) ? $clog2(NU) : 1,
   localparam int PW = $clog2(NU + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spawn_req,
   input  logic [TW-1:0] spawn_tag,
   input  logic [PW-1:0] spawn_pos,
   input  logic [UW-1:0] spawn_parent,
   output logic          spawn_rdy,
   output logic          spawn_gnt,
   output logic          spawn_drop,
   output logic [UW-1:0] spawn_unit,
   input  logic [NU-1:0] slice_done,
   input  logic          fin_valid,
   input  logic [UW-1:0] fin_unit,
   input  logic [TW-1:0] fin_tag,
   output logic          val_req,
   output logic [UW-1:0] val_unit,
   input  logic          val_rsp_v,
   input  logic          val_rsp_ok,
   output logic [NU-1:0] squash,
   output logic [NU-1:0] free,
   output logic          head_valid,
   output logic [UW-1:0] head_unit,
   output logic [PW-1:0] live_cnt
);
   if (NU < 2) begin : g_bad_nu
      $error("spec_order_mgr: NU must be at least 2");
   end
   if (TW < 1) begin : g_bad_tw
      $error("spec_order_mgr: TW must be positive");
   end

   logic [NU-1:0][UW-1:0] ord;
   logic [PW-1:0]         cnt;
   logic [NU-1:0]         member, held, avail, kill;
   logic [UW-1:0]         last_u, head, nxt, pick_u, gunit;
   logic                  pick_ok;
   logic [NU-1:0][TW-1:0] tag_r, ftag_r;
   logic [NU-1:0]         fin_r;
   logic                  hfin, two, tag_ok, mism, alone, vreq, vpass, vfail, sfx;
   logic                  acc, evict, grant, drop;
   logic [PW-1:0]         slot;
   head_act_e             act;

   assign head  = ord[0];
   assign nxt   = ord[1];
   assign hfin  = (cnt != '0) && fin_r[head];
   assign two   = cnt >= PW'(2);
   assign tag_ok = ftag_r[head] == tag_r[nxt];
   assign mism  = hfin && two && !tag_ok;
   assign alone = hfin && !two;
   assign vreq  = hfin && two && tag_ok;
   assign vpass = vreq && val_rsp_v && val_rsp_ok;
   assign vfail = vreq && val_rsp_v && !val_rsp_ok;
   assign sfx   = mism || vfail;

   always_comb begin
      if (sfx)        act = HD_SQUASH;
      else if (vpass) act = HD_COMMIT;
      else if (alone) act = HD_RESUME;
      else            act = HD_IDLE;
   end

   // slot clamp: never ahead of the non-speculative thread
   always_comb begin
      if (cnt == '0)            slot = '0;
      else if (spawn_pos == '0) slot = PW'(1);
      else if (spawn_pos > cnt) slot = cnt;
      else                      slot = spawn_pos;
   end

   assign avail = ~(member | held);

   som_pick #(.N(NU), .IW(UW)) u_pick (
      .req   (avail),
      .found (pick_ok),
      .idx   (pick_u)
   );

   assign acc   = spawn_req && !hfin;
   assign evict = acc && !pick_ok && (slot < cnt);
   assign grant = acc && (pick_ok || evict);
   assign drop  = acc && !grant;
   assign gunit = pick_ok ? pick_u : last_u;

   always_comb begin
      kill = '0;
      if (evict)    kill[last_u] = 1'b1;
      else if (sfx) kill = member & ~(NU'(1) << head);
   end

   som_list #(.NU(NU), .UW(UW), .PW(PW)) u_list (
      .clk       (clk),
      .rst_n     (rst_n),
      .trunc_en  (evict || sfx),
      .trunc_len (sfx ? PW'(1) : cnt - 1'b1),
      .pop_en    (vpass),
      .ins_en    (grant),
      .ins_pos   (slot),
      .ins_unit  (gunit),
      .ord       (ord),
      .cnt       (cnt),
      .member    (member),
      .last_unit (last_u)
   );

   som_slice #(.NU(NU), .UW(UW)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_en     (grant),
      .start_unit   (gunit),
      .start_parent (spawn_parent),
      .kill         (kill),
      .done         (slice_done),
      .commit_en    (vpass),
      .commit_unit  (head),
      .held         (held),
      .free_p       (free)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fin_r      <= '0;
         tag_r      <= '0;
         ftag_r     <= '0;
         spawn_gnt  <= 1'b0;
         spawn_drop <= 1'b0;
         spawn_unit <= '0;
         squash     <= '0;
      end else begin
         spawn_gnt  <= grant;
         spawn_drop <= drop;
         if (grant) spawn_unit <= gunit;
         squash     <= kill;
         for (int u = 0; u < NU; u++) begin
            if (grant && gunit == UW'(u)) begin
               tag_r[u] <= spawn_tag;
               fin_r[u] <= 1'b0;
            end else if (kill[u]) begin
               fin_r[u] <= 1'b0;
            end else if (act != HD_IDLE && head == UW'(u)) begin
               fin_r[u] <= 1'b0;
            end else if (fin_valid && fin_unit == UW'(u) && member[u]) begin
               fin_r[u]  <= 1'b1;
               ftag_r[u] <= fin_tag;
            end
         end
      end
   end

   assign spawn_rdy  = !hfin;
   assign val_req    = vreq;
   assign val_unit   = nxt;
   assign head_valid = cnt != '0;
   assign head_unit  = head;
   assign live_cnt   = cnt;

   // R2
   gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(spawn_gnt && spawn_drop));
   // R4
   evict_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spawn_gnt && squash != '0) |-> squash == (NU'(1) << spawn_unit));
   // R7
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spawn_req && !spawn_rdy) |=> !(spawn_gnt || spawn_drop));
   // R8
   mism_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mism |=> (live_cnt == PW'(1)) && spawn_rdy);
   // R10
   fail_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vfail |=> (live_cnt == PW'(1)) && (free == '0));
   // R11
   commit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vpass |=> live_cnt == $past(live_cnt) - PW'(1));
   // R11
   squash_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (squash & free) == '0);
endmodule

// File: tb/sim_spec_order_mgr.sv
module sim_spec_order_mgr;
   localparam int NU = 4;
   localparam int TW = 8;
   localparam int UW = 2;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spawn_req = 1'b0;
   logic [TW-1:0] spawn_tag = '0;
   logic [PW-1:0] spawn_pos = '0;
   logic [UW-1:0] spawn_parent = '0;
   logic          spawn_rdy, spawn_gnt, spawn_drop;
   logic [UW-1:0] spawn_unit;
   logic [NU-1:0] slice_done = '0;
   logic          fin_valid = 1'b0;
   logic [UW-1:0] fin_unit = '0;
   logic [TW-1:0] fin_tag = '0;
   logic          val_req;
   logic [UW-1:0] val_unit;
   logic          val_rsp_v = 1'b0;
   logic          val_rsp_ok = 1'b0;
   logic [NU-1:0] squash, free;
   logic          head_valid;
   logic [UW-1:0] head_unit;
   logic [PW-1:0] live_cnt;

   spec_order_mgr #(.NU(NU), .TW(TW)) u0 (.*);

   always #2 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   int m_ord[5];
   int m_tag[4];
   bit m_busy[4];
   int m_cnt = 0;

   task automatic chk(input string rq, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic m_ins(input int p, input int u);
      for (int i = m_cnt; i > p; i--) m_ord[i] = m_ord[i-1];
      m_ord[p] = u;
      m_cnt++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      spawn_req = 1'b0; fin_valid = 1'b0; val_rsp_v = 1'b0; slice_done = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_busy[i] = 1'b0; m_ord[i] = 0; end
   endtask

   task automatic do_spawn(input int tag, input int pos, input int parent,
                           input bit sdone, input string rq);
      int pp, f, exp_u, exp_sq;
      bit exp_g;
      spawn_req = 1'b1; spawn_tag = TW'(tag); spawn_pos = PW'(pos);
      spawn_parent = UW'(parent);
      while (!spawn_rdy) @(negedge clk);
      if (m_cnt == 0)      pp = 0;
      else if (pos == 0)   pp = 1;
      else if (pos > m_cnt) pp = m_cnt;
      else                 pp = pos;
      f = -1;
      for (int i = 3; i >= 0; i--) if (!m_busy[i]) f = i;
      exp_sq = 0; exp_g = 1'b1; exp_u = 0;
      if (f >= 0) begin
         exp_u = f; m_busy[f] = 1'b1; m_ins(pp, f);
      end else if (pp < m_cnt) begin
         exp_u = m_ord[m_cnt-1]; exp_sq = 1 << exp_u; m_cnt--; m_ins(pp, exp_u);
      end else begin
         exp_g = 1'b0;
      end
      @(negedge clk);
      spawn_req = 1'b0;
      chk(rq, spawn_gnt, exp_g);
      chk(rq, spawn_drop, !exp_g);
      if (exp_g) chk(rq, spawn_unit, exp_u);
      chk(rq, squash, exp_sq);
      chk(rq, live_cnt, m_cnt);
      chk("R6", head_unit, m_ord[0]);
      if (exp_g) begin
         m_tag[exp_u] = tag;
         if (sdone) begin
            slice_done = NU'(1) << exp_u;
            @(negedge clk);
            slice_done = '0;
         end
      end
   endtask

   task automatic drain();
      while (m_cnt > 1) begin
         int h, n;
         h = m_ord[0]; n = m_ord[1];
         fin_valid = 1'b1; fin_unit = UW'(h); fin_tag = TW'(m_tag[n]);
         @(negedge clk);
         fin_valid = 1'b0;
         chk("R9", val_req, 1);
         chk("R9", val_unit, n);
         val_rsp_v = 1'b1; val_rsp_ok = 1'b1;
         @(negedge clk);
         val_rsp_v = 1'b0;
         for (int i = 0; i < m_cnt - 1; i++) m_ord[i] = m_ord[i+1];
         m_cnt--; m_busy[h] = 1'b0;
         chk("R11", free, 1 << h);
         chk("R11", head_unit, n);
         chk("R11", live_cnt, m_cnt);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", head_valid, 0);
      chk("R1", live_cnt, 0);
      chk("R1", spawn_rdy, 1);
      chk("R1", val_req, 0);
      chk("R1", squash, 0);
      chk("R1", free, 0);
      chk("R1", spawn_gnt, 0);
      chk("R1", spawn_drop, 0);

      // sweep of slots, then a fifth spawn into a full pool
      for (int a = 0; a <= 4; a++)
         for (int b = 0; b <= 4; b++)
            for (int c = 0; c <= 4; c++)
               for (int d = 0; d <= 4; d++) begin
                  do_reset();
                  do_spawn(8'h20, 0, 0, 1'b1, "R2");
                  do_spawn(8'h21, a, m_ord[0], 1'b1, "R3");
                  do_spawn(8'h22, b, m_ord[0], 1'b1, "R3");
                  do_spawn(8'h23, c, m_ord[0], 1'b1, "R3");
                  do_spawn(8'h24, d, m_ord[0], 1'b1, (d == 4) ? "R5" : "R4");
                  chk("R6", head_valid, 1);
                  drain();
               end

      // R8 order mismatch squashes the suffix
      do_reset();
      for (int k = 0; k < 3; k++) do_spawn(8'h40 + k, 4, 0, 1'b1, "R2");
      fin_valid = 1'b1; fin_unit = 2'd0; fin_tag = 8'hEE;
      @(negedge clk);
      fin_valid = 1'b0;
      chk("R7", spawn_rdy, 0);
      chk("R8", val_req, 0);
      @(negedge clk);
      chk("R8", squash, 4'b0110);
      chk("R8", live_cnt, 1);
      chk("R8", head_unit, 0);
      chk("R8", spawn_rdy, 1);
      m_cnt = 1; m_busy[1] = 1'b0; m_busy[2] = 1'b0;
      do_spawn(8'h50, 4, 0, 1'b1, "R8");

      // R10 failed value check
      do_reset();
      for (int k = 0; k < 3; k++) do_spawn(8'h60 + k, 4, 0, 1'b1, "R2");
      fin_valid = 1'b1; fin_unit = 2'd0; fin_tag = 8'h61;
      @(negedge clk);
      fin_valid = 1'b0;
      chk("R10", val_req, 1);
      chk("R10", val_unit, 1);
      val_rsp_v = 1'b1; val_rsp_ok = 1'b0;
      @(negedge clk);
      val_rsp_v = 1'b0;
      chk("R10", squash, 4'b0110);
      chk("R10", live_cnt, 1);
      chk("R10", free, 0);
      chk("R10", head_unit, 0);

      // R13 lone finishing thread carries on
      do_reset();
      do_spawn(8'h70, 0, 0, 1'b1, "R2");
      fin_valid = 1'b1; fin_unit = 2'd0; fin_tag = 8'h05;
      @(negedge clk);
      fin_valid = 1'b0;
      chk("R13", spawn_rdy, 0);
      @(negedge clk);
      chk("R13", spawn_rdy, 1);
      chk("R13", live_cnt, 1);
      chk("R13", squash, 0);
      chk("R13", val_req, 0);
      // R7 finish for an inactive unit is ignored
      fin_valid = 1'b1; fin_unit = 2'd3; fin_tag = 8'h05;
      @(negedge clk);
      fin_valid = 1'b0;
      @(negedge clk);
      chk("R7", spawn_rdy, 1);
      chk("R7", live_cnt, 1);

      // R7 early finish of a speculative thread waits for its turn
      do_reset();
      for (int k = 0; k < 3; k++) do_spawn(8'h80 + k, 4, 0, 1'b1, "R2");
      fin_valid = 1'b1; fin_unit = 2'd1; fin_tag = 8'h82;
      @(negedge clk);
      fin_unit = 2'd0; fin_tag = 8'h81;
      chk("R7", val_req, 0);
      chk("R7", spawn_rdy, 1);
      @(negedge clk);
      fin_valid = 1'b0;
      chk("R9", val_req, 1);
      chk("R9", val_unit, 1);
      val_rsp_v = 1'b1; val_rsp_ok = 1'b1;
      @(negedge clk);
      chk("R11", free, 4'b0001);
      chk("R7", head_unit, 1);
      chk("R7", val_req, 1);
      chk("R7", val_unit, 2);
      @(negedge clk);
      val_rsp_v = 1'b0;
      chk("R11", free, 4'b0010);
      chk("R11", head_unit, 2);
      chk("R11", live_cnt, 1);

      // R12 commit held by a child still in its slice
      do_reset();
      do_spawn(8'h90, 0, 0, 1'b1, "R2");
      do_spawn(8'h91, 4, 0, 1'b0, "R2");
      fin_valid = 1'b1; fin_unit = 2'd0; fin_tag = 8'h91;
      @(negedge clk);
      fin_valid = 1'b0;
      val_rsp_v = 1'b1; val_rsp_ok = 1'b1;
      @(negedge clk);
      val_rsp_v = 1'b0;
      chk("R12", free, 0);
      chk("R12", head_unit, 1);
      chk("R12", live_cnt, 1);
      m_ord[0] = 1; m_cnt = 1;
      do_spawn(8'h92, 4, 1, 1'b1, "R12");
      chk("R12", free, 0);
      slice_done = 4'b0010;
      @(negedge clk);
      slice_done = '0;
      chk("R12", free, 0);
      @(negedge clk);
      chk("R12", free, 4'b0001);
      @(negedge clk);
      chk("R12", free, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule